// File: doc/BRIEF.md
# Dual-Mode Priority Interrupt Controller

This block gathers 47 level-sensitive interrupt requests, 44 from on-chip peripherals and 3 from external pins, and gates each one with its own enable bit. A fixed-priority encoder picks one winner among the pending, enabled requests. The winner's number is published as a 6-bit cause code, and a separate flag shows when nothing is pending. The cause number 31 is left unused, so the sources take the numbers 0 to 30 and 32 to 47.

The block also drives an 8-bit CPU pending vector. A mode input selects how the upper bits of that vector are filled. In native mode the upper five bits carry the cause number, saturated at 31. A handler that reads 31 there knows it must fetch the full 6-bit cause. In compatible mode the vector has a single summary bit plus four direct bits. Each direct bit follows one programmable source, whether or not that source wins the priority contest. The core's own timer and software interrupts do not pass through this block, so the two lowest bits of the vector stay 0.

Every output is registered. The outputs reflect the inputs sampled at the previous rising clock edge.

Top module: `intc_dual_mode`

## Requirements
- R1: Request line `irq_req[i]` has cause number i for i from 0 to 30, and cause number i+1 for i from 31 to 46. The cause output is never 31, and it is never above 47.
- R2: The pending, enabled request with the lowest cause number wins. All outputs change one clock after the inputs that cause the change are sampled on a rising edge, and they hold their old values until that edge.
- R3: A request whose `irq_en` bit is 0 has no effect. It does not change the cause, the summary bit or any direct bit.
- R4: `cpu_ip[2]` is the summary bit. In both modes it is 1 exactly when at least one enabled request is pending.
- R5: In compatible mode (`native_mode`=0), `cpu_ip[7]` is 0. `cpu_ip[3+k]`, for k from 0 to 3, is 1 when `route_vld[k]` is 1 and the request whose cause number equals `route_sel[6k+5:6k]` is pending and enabled. This holds whatever the priority result.
- R6: In native mode (`native_mode`=1), `cpu_ip[7:3]` equals the cause when the cause is below 31, and equals 31 when the cause is above 31. The route settings have no effect in this mode.
- R7: When no enabled request is pending, `irq_cause` is 0, `irq_none` is 1 and `cpu_ip` is 0, in both modes.
- R8: `cpu_ip[1:0]` is always 0.
- R9: The reset is synchronous and active high. While it is sampled high, the outputs go to `irq_cause`=0, `irq_none`=1 and `cpu_ip`=0.
- R10: A direct slot never sets its bit when it names a cause number that no request has (31, or above 47), or when its valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 47 | Level-sensitive request lines |
| irq_en | input | 47 | Per-request enable mask |
| native_mode | input | 1 | 1 selects native reporting, 0 selects compatible reporting |
| route_sel | input | 24 | Four 6-bit cause numbers, one per direct slot; slot k uses bits [6k+5:6k] |
| route_vld | input | 4 | Valid bit for each direct slot |
| irq_cause | output | 6 | Registered cause number of the winning request |
| irq_none | output | 1 | Registered flag: no enabled request is pending |
| cpu_ip | output | 8 | Registered CPU pending vector |

## Verification
The hardest case to reach from the ports is a direct bit that tracks a request that loses the priority contest. Another hard case is a slot that names a lower-priority request whose enable has just been cleared. The stimulus table sets up both cases: two requests are pending at once, the slots point at the losing request, and in one row that request's enable is removed. Saturation is reached by raising only requests at or above line 31, and by switching the mode with the route settings held fixed. This shows that the native vector ignores the slots.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Map a request line index to its cause number; the value skip_num is never used.
  function automatic int src_to_cause(input int idx, input int skip_num);
    return (idx < skip_num) ? idx : idx + 1;
  endfunction

endpackage

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int NUM_SRC  = 47,
  parameter int CAUSE_W  = 6,
  parameter int SKIP_NUM = 31
) (
  input  logic [NUM_SRC-1:0] active,
  output logic [CAUSE_W-1:0] cause,
  output logic               any
);
  import intc_pkg::*;

  // Scan from the top down so that the lowest active line is the last assignment.
  always_comb begin
    cause = '0;
    any   = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        cause = CAUSE_W'(src_to_cause(i, SKIP_NUM));
        any   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/intc_route_slot.sv
module intc_route_slot #(
  parameter int NUM_SRC  = 47,
  parameter int CAUSE_W  = 6,
  parameter int SKIP_NUM = 31
) (
  input  logic [NUM_SRC-1:0] active,
  input  logic [CAUSE_W-1:0] sel,
  input  logic               vld,
  output logic               hit
);
  import intc_pkg::*;

  // Compare against each line's cause number; unused numbers match nothing.
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (vld && active[i] && (sel == CAUSE_W'(src_to_cause(i, SKIP_NUM))))
        hit = 1'b1;
    end
  end

endmodule

// File: rtl/intc_ip_pack.sv
module intc_ip_pack #(
  parameter int CAUSE_W    = 6,
  parameter int FIELD_W    = 5,
  parameter int NUM_DIRECT = 4
) (
  input  logic                  native,
  input  logic                  any,
  input  logic [CAUSE_W-1:0]    cause,
  input  logic [NUM_DIRECT-1:0] direct,
  output logic [FIELD_W:0]      ip_hi
);
  localparam int PAD = FIELD_W - NUM_DIRECT;
  localparam logic [CAUSE_W-1:0] SAT = CAUSE_W'((1 << FIELD_W) - 1);

  logic [FIELD_W-1:0] packed_cause;
  logic [FIELD_W-1:0] compat_hi;

  always_comb begin
    if (cause > SAT) packed_cause = SAT[FIELD_W-1:0];
    else             packed_cause = cause[FIELD_W-1:0];
  end

  generate
    if (PAD > 0) begin : g_pad
      assign compat_hi = {{PAD{1'b0}}, direct};
    end else begin : g_nopad
      assign compat_hi = direct[FIELD_W-1:0];
    end
  endgenerate

  always_comb begin
    if (native) ip_hi = {(any ? packed_cause : {FIELD_W{1'b0}}), any};
    else        ip_hi = {compat_hi, any};
  end

endmodule

// File: rtl/intc_dual_mode.sv
module intc_dual_mode #(
  parameter int NUM_SRC    = 47,
  parameter int CAUSE_W    = 6,
  parameter int FIELD_W    = 5,
  parameter int NUM_DIRECT = 4,
  parameter int SKIP_NUM   = 31,
  localparam int SEL_W     = NUM_DIRECT * CAUSE_W,
  localparam int IP_W      = FIELD_W + 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    irq_req,
  input  logic [NUM_SRC-1:0]    irq_en,
  input  logic                  native_mode,
  input  logic [SEL_W-1:0]      route_sel,
  input  logic [NUM_DIRECT-1:0] route_vld,
  output logic [CAUSE_W-1:0]    irq_cause,
  output logic                  irq_none,
  output logic [IP_W-1:0]       cpu_ip
);
  localparam logic [CAUSE_W-1:0] MAX_CAUSE = CAUSE_W'(NUM_SRC);
  localparam logic [CAUSE_W-1:0] SKIP_C    = CAUSE_W'(SKIP_NUM);
  localparam logic [FIELD_W-1:0] SAT_F     = {FIELD_W{1'b1}};

  logic [NUM_SRC-1:0]    active;
  logic [CAUSE_W-1:0]    win_cause;
  logic                  win_any;
  logic [NUM_DIRECT-1:0] direct_hit;
  logic [FIELD_W:0]      ip_hi_d;

  logic [CAUSE_W-1:0]    cause_q;
  logic                  none_q;
  logic [FIELD_W:0]      ip_hi_q;
  logic                  mode_q;

  assign active = irq_req & irq_en;

  intc_prio_enc #(.NUM_SRC(NUM_SRC), .CAUSE_W(CAUSE_W), .SKIP_NUM(SKIP_NUM)) u_enc (
    .active(active), .cause(win_cause), .any(win_any)
  );

  generate
    for (genvar k = 0; k < NUM_DIRECT; k++) begin : g_slot
      intc_route_slot #(.NUM_SRC(NUM_SRC), .CAUSE_W(CAUSE_W), .SKIP_NUM(SKIP_NUM)) u_slot (
        .active(active),
        .sel   (route_sel[k*CAUSE_W +: CAUSE_W]),
        .vld   (route_vld[k]),
        .hit   (direct_hit[k])
      );
    end
  endgenerate

  intc_ip_pack #(.CAUSE_W(CAUSE_W), .FIELD_W(FIELD_W), .NUM_DIRECT(NUM_DIRECT)) u_pack (
    .native(native_mode), .any(win_any), .cause(win_cause),
    .direct(direct_hit), .ip_hi(ip_hi_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      none_q  <= 1'b1;
      ip_hi_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      cause_q <= win_cause;
      none_q  <= ~win_any;
      ip_hi_q <= ip_hi_d;
      mode_q  <= native_mode;
    end
  end

  assign irq_cause = cause_q;
  assign irq_none  = none_q;
  assign cpu_ip    = {ip_hi_q, 2'b00};

  // R1: the skipped number and numbers past the last line never appear
  assert_cause_range_R1: assert property (@(posedge clk) disable iff (rst)
    !none_q |-> (cause_q != SKIP_C) && (cause_q <= MAX_CAUSE));

  // R7: idle state reports zero everywhere
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    none_q |-> (cause_q == '0) && (ip_hi_q == '0));

  // R4: summary bit tracks the pending flag
  assert_summary_R4: assert property (@(posedge clk) disable iff (rst)
    ip_hi_q[0] == !none_q);

  // R6: native field follows the cause register, saturated
  assert_native_sat_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !none_q) |->
      (ip_hi_q[FIELD_W:1] == ((cause_q > CAUSE_W'(SAT_F)) ? SAT_F : cause_q[FIELD_W-1:0])));

  // R5: top pending bit stays clear in compatible mode
  assert_compat_top_R5: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> !ip_hi_q[FIELD_W]);

  // R9: one cycle after reset is sampled, outputs are at their reset values
  assert_reset_state_R9: assert property (@(posedge clk)
    $past(rst) |-> (cause_q == '0) && none_q && (ip_hi_q == '0));

endmodule

// File: tb/tb_intc_dual_mode.sv
module tb_intc_dual_mode;
  localparam int NS = 47;

  typedef struct packed {
    logic        mode;
    logic [46:0] req;
    logic [46:0] en;
    logic [3:0]  vld;
    logic [23:0] sel;
    logic [5:0]  cause;
    logic        none;
    logic [7:0]  ip;
  } vec_t;

  localparam logic [46:0] ALL = {47{1'b1}};
  localparam logic [46:0] B5  = 47'd1 << 5;
  localparam logic [46:0] B40 = 47'd1 << 40;
  localparam int NV = 14;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 47'd1,                 ALL,        4'h0,   24'h0,                       6'd0,  1'b0, 8'h04}, // 0 R1 R4
    '{1'b1, B5 | B40,              ALL,        4'h0,   24'h0,                       6'd5,  1'b0, 8'h2C}, // 1 R2 R6
    '{1'b1, 47'd1 << 30,           ALL,        4'h0,   24'h0,                       6'd30, 1'b0, 8'hF4}, // 2 R6
    '{1'b1, 47'd1 << 31,           ALL,        4'h0,   24'h0,                       6'd32, 1'b0, 8'hFC}, // 3 R1 R6
    '{1'b1, 47'd1 << 46,           ALL,        4'h0,   24'h0,                       6'd47, 1'b0, 8'hFC}, // 4 R1
    '{1'b1, (47'd1<<3)|(47'd1<<10), 47'd1<<10, 4'h0,   24'h0,                       6'd10, 1'b0, 8'h54}, // 5 R3
    '{1'b1, 47'd1 << 3,            47'd0,      4'h0,   24'h0,                       6'd0,  1'b1, 8'h00}, // 6 R7
    '{1'b0, B5,                    ALL,        4'h0,   24'h0,                       6'd5,  1'b0, 8'h04}, // 7 R4
    '{1'b0, B5 | B40,              ALL,        4'b0011, {6'd0,6'd0,6'd5,6'd41},     6'd5,  1'b0, 8'h1C}, // 8 R5
    '{1'b0, B5 | B40,              ALL & ~B40, 4'b0100, {6'd0,6'd41,6'd0,6'd0},     6'd5,  1'b0, 8'h04}, // 9 R3
    '{1'b0, ALL,                   ALL,        4'b1100, {6'd31,6'd50,6'd0,6'd0},    6'd0,  1'b0, 8'h04}, // 10 R10
    '{1'b0, 47'd1 << 46,           ALL,        4'b1000, {6'd47,6'd0,6'd0,6'd0},     6'd47, 1'b0, 8'h44}, // 11 R5
    '{1'b1, 47'd1 << 46,           ALL,        4'b1000, {6'd47,6'd0,6'd0,6'd0},     6'd47, 1'b0, 8'hFC}, // 12 R6
    '{1'b0, 47'd0,                 ALL,        4'b1111, {6'd1,6'd2,6'd3,6'd4},      6'd0,  1'b1, 8'h00}  // 13 R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [46:0] irq_req = '0;
  logic [46:0] irq_en = '0;
  logic        native_mode = 1'b0;
  logic [23:0] route_sel = '0;
  logic [3:0]  route_vld = '0;
  logic [5:0]  irq_cause;
  logic        irq_none;
  logic [7:0]  cpu_ip;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  intc_dual_mode dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
    .native_mode(native_mode), .route_sel(route_sel), .route_vld(route_vld),
    .irq_cause(irq_cause), .irq_none(irq_none), .cpu_ip(cpu_ip)
  );

  function automatic string tag_of(input int i);
    case (i)
      0: return "R1 R4 R8";   1: return "R2 R6";   2: return "R6 R8";
      3: return "R1 R6";      4: return "R1 R6";   5: return "R3";
      6: return "R7 R3";      7: return "R4 R5";   8: return "R5 R8";
      9: return "R3 R5";      10: return "R10";    11: return "R5";
      12: return "R6";        default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    native_mode = v.mode; irq_req = v.req; irq_en = v.en;
    route_vld = v.vld; route_sel = v.sel;
  endtask

  task automatic check_all(input string tag, input logic [5:0] c, input logic n, input logic [7:0] ip);
    chk({tag, " cause"}, {2'b00, irq_cause}, {2'b00, c});
    chk({tag, " none"},  {7'd0, irq_none},   {7'd0, n});
    chk({tag, " ip"},    cpu_ip,             ip);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_all("R9 reset", 6'd0, 1'b1, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check_all($sformatf("vec%0d %s", i, tag_of(i)), VECS[i].cause, VECS[i].none, VECS[i].ip);
    end

    // R2: output holds until the next rising edge, then updates
    @(negedge clk);
    drive(VECS[1]);
    @(negedge clk);
    irq_req = 47'd1 << 2;
    #1;
    check_all("R2 hold", 6'd5, 1'b0, 8'h2C);
    @(negedge clk);
    check_all("R2 update", 6'd2, 1'b0, 8'h14);

    // R9: synchronous reset in mid-run
    rst = 1'b1;
    #1;
    check_all("R9 sync", 6'd2, 1'b0, 8'h14);
    @(negedge clk);
    check_all("R9 midrun", 6'd0, 1'b1, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check_all("R9 release", 6'd2, 1'b0, 8'h14);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule